// File: doc/BRIEF.md
# Write-Once Snooping Line Coherence Controller

This block keeps the coherence state of every line of a direct-mapped data cache under a four-state write-once scheme, and answers the bus cycles that other processors issue. Each line is in one of four states: absent, clean and possibly shared, clean and exclusive, or modified and exclusive. On a local access the controller decides whether the access hits. It then picks the bus cycle the miss or write needs and flags a dirty victim that must be written back. On a snooped cycle it decides whether this cache supplies the data and where the line ends up. Regular reads and read-for-ownership cycles are handled, and so are their transactional counterparts.

The first write to a clean shared line goes through to memory and leaves the line exclusive and clean. Later writes stay in the cache and make the line modified. The tag and data arrays are outside this block. Tag comparison results come in as match inputs, and every decision comes out as registered pulses one cycle after the request. A local access and a snoop may arrive in the same cycle. When both target the same index, the snoop is applied first.

Top module: `wo_coherence_ctrl`

## Requirements
- R1: After reset every line is absent (state code 0), and all response pulses (`bus_req_vld_o`, `evict_o`, `snp_supply_o`) are low. A local read with a tag match to any index is then a miss.
- R2: A local read with a tag match to a held line (state code nonzero) is a hit: no bus request and the state is unchanged. Any other read issues bus op READ (code 0) and leaves the line clean-shared (code 1).
- R3: A local write that hits a clean-shared line (code 1) issues a write-through, bus op WRITE (code 2), and leaves the line clean-exclusive (code 2).
- R4: A local write that hits a clean-exclusive (code 2) or modified (code 3) line issues no bus request and leaves the line modified (code 3).
- R5: A local write that misses (no tag match, or line absent) issues bus op RFO (code 1) and leaves the line modified (code 3).
- R6: A local access without a tag match to a modified line raises `evict_o` together with its fill request. No other access raises `evict_o`.
- R7: A snooped READ (code 0) or T_READ (code 3) with a tag match on a held line raises `snp_supply_o`, and the line becomes clean-shared (code 1).
- R8: A snooped RFO (code 1) or T_RFO (code 4) with a tag match on a held line raises `snp_supply_o`, and the line becomes absent (code 0).
- R9: A snoop with no tag match, a snoop to an absent line, a snooped WRITE (code 2), and the unused codes 5 to 7 supply nothing and leave the line state unchanged.
- R10: Every response (pulses, `cpu_state_o`, `snp_state_o`, `cpu_hit_o`) is registered. It appears in the cycle after the request and not in the request cycle.
- R11: When a local access and a matching snoop target the same index in one cycle, the snoop's effect is applied first and the local access is decided on the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid_i | input | 1 | Local access present this cycle |
| cpu_write_i | input | 1 | Local access is a write |
| cpu_idx_i | input | IDX_W | Line index of local access |
| cpu_match_i | input | 1 | Tag of local access matches stored tag |
| snp_valid_i | input | 1 | Snooped bus cycle present this cycle |
| snp_op_i | input | 3 | Snooped bus op: 0 READ, 1 RFO, 2 WRITE, 3 T_READ, 4 T_RFO |
| snp_idx_i | input | IDX_W | Line index of snooped address |
| snp_match_i | input | 1 | Snooped tag matches stored tag |
| bus_req_vld_o | output | 1 | Bus request pulse for a local access |
| bus_req_op_o | output | 3 | Op of that request (same codes as snp_op_i) |
| evict_o | output | 1 | Dirty victim must be written back (WRITE cycle) |
| cpu_hit_o | output | 1 | Last local access hit |
| cpu_state_o | output | 2 | Line state after the last local access |
| snp_supply_o | output | 1 | This cache supplies data for the last snoop |
| snp_state_o | output | 2 | Line state after the last snoop |

## Verification
The hardest situation to reach is a snoop and a local access that land on the same index in the same cycle. The local decision must then use the state the snoop has just produced, not the stored one. The bench first drives the line into each of the four states through ordinary local traffic. It then issues every defined snoop op together with a read or a write to that index in one cycle. It compares both responses with a model that applies the snoop before the access. The sweeps also step every state through every snoop code with and without a tag match, so the unused codes and the no-effect cases are observed through `snp_state_o`.

// File: rtl/wo_coh_pkg.sv
package wo_coh_pkg;
  typedef enum logic [1:0] {
    LS_ABSENT = 2'd0,
    LS_SHARED = 2'd1,
    LS_EXCL   = 2'd2,
    LS_MOD    = 2'd3
  } line_st_t;

  typedef enum logic [2:0] {
    BOP_READ  = 3'd0,
    BOP_RFO   = 3'd1,
    BOP_WRITE = 3'd2,
    BOP_TREAD = 3'd3,
    BOP_TRFO  = 3'd4
  } bus_op_t;
endpackage

// File: rtl/wo_snoop_xfer.sv
module wo_snoop_xfer
  import wo_coh_pkg::*;
(
  input  line_st_t  cur_st,
  input  logic      active,
  input  logic [2:0] op,
  output line_st_t  nxt_st,
  output logic      supply
);
  logic held;
  assign held = active && (cur_st != LS_ABSENT);

  always_comb begin
    nxt_st = cur_st;
    supply = 1'b0;
    if (held) begin
      case (op)
        BOP_READ, BOP_TREAD: begin
          supply = 1'b1;
          nxt_st = LS_SHARED;
        end
        BOP_RFO, BOP_TRFO: begin
          supply = 1'b1;
          nxt_st = LS_ABSENT;
        end
        default: begin
          supply = 1'b0;
          nxt_st = cur_st;
        end
      endcase
    end
  end
endmodule

// File: rtl/wo_local_xfer.sv
module wo_local_xfer
  import wo_coh_pkg::*;
(
  input  line_st_t   cur_st,
  input  logic       active,
  input  logic       is_write,
  input  logic       tag_match,
  output line_st_t   nxt_st,
  output logic       hit,
  output logic       req_vld,
  output logic [2:0] req_op,
  output logic       evict
);
  assign hit   = tag_match && (cur_st != LS_ABSENT);
  assign evict = active && !tag_match && (cur_st == LS_MOD);

  always_comb begin
    nxt_st  = cur_st;
    req_vld = 1'b0;
    req_op  = BOP_READ;
    if (active) begin
      if (!hit) begin
        req_vld = 1'b1;
        req_op  = is_write ? BOP_RFO : BOP_READ;
        nxt_st  = is_write ? LS_MOD : LS_SHARED;
      end else if (is_write) begin
        if (cur_st == LS_SHARED) begin
          req_vld = 1'b1;
          req_op  = BOP_WRITE;
          nxt_st  = LS_EXCL;
        end else begin
          nxt_st = LS_MOD;
        end
      end
    end
  end
endmodule

// File: rtl/wo_line_store.sv
module wo_line_store
  import wo_coh_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lw_en,
  input  logic [IDX_W-1:0] lw_idx,
  input  line_st_t         lw_st,
  input  logic             sw_en,
  input  logic [IDX_W-1:0] sw_idx,
  input  line_st_t         sw_st,
  input  logic [IDX_W-1:0] ra_idx,
  output line_st_t         ra_st,
  input  logic [IDX_W-1:0] rb_idx,
  output line_st_t         rb_st
);
  logic [2*LINES-1:0] st_vec;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic     l_we, s_we, cell_en;
    line_st_t cell_d, cell_q;

    assign l_we    = lw_en && (lw_idx == IDX_W'(i));
    assign s_we    = sw_en && (sw_idx == IDX_W'(i));
    assign cell_en = l_we || s_we;
    assign cell_d  = l_we ? lw_st : sw_st;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= LS_ABSENT;
      else if (cell_en) cell_q <= cell_d;
    end

    assign st_vec[2*i +: 2] = cell_q;
  end

  assign ra_st = line_st_t'(st_vec[2*ra_idx +: 2]);
  assign rb_st = line_st_t'(st_vec[2*rb_idx +: 2]);
endmodule

// File: rtl/wo_coherence_ctrl.sv
module wo_coherence_ctrl
  import wo_coh_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid_i,
  input  logic             cpu_write_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic             cpu_match_i,
  input  logic             snp_valid_i,
  input  logic [2:0]       snp_op_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic             snp_match_i,
  output logic             bus_req_vld_o,
  output logic [2:0]       bus_req_op_o,
  output logic             evict_o,
  output logic             cpu_hit_o,
  output logic [1:0]       cpu_state_o,
  output logic             snp_supply_o,
  output logic [1:0]       snp_state_o
);
  line_st_t   snp_cur, snp_nxt, arr_cpu_st, cpu_cur, cpu_nxt;
  logic       snp_act, snp_sup, same_idx;
  logic       loc_hit, loc_req, loc_evict;
  logic [2:0] loc_op;

  assign snp_act = snp_valid_i && snp_match_i;

  wo_line_store #(.IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .lw_en  (cpu_valid_i),
    .lw_idx (cpu_idx_i),
    .lw_st  (cpu_nxt),
    .sw_en  (snp_act),
    .sw_idx (snp_idx_i),
    .sw_st  (snp_nxt),
    .ra_idx (snp_idx_i),
    .ra_st  (snp_cur),
    .rb_idx (cpu_idx_i),
    .rb_st  (arr_cpu_st)
  );

  wo_snoop_xfer u_snoop (
    .cur_st (snp_cur),
    .active (snp_act),
    .op     (snp_op_i),
    .nxt_st (snp_nxt),
    .supply (snp_sup)
  );

  assign same_idx = snp_act && (snp_idx_i == cpu_idx_i);
  assign cpu_cur  = same_idx ? snp_nxt : arr_cpu_st;

  wo_local_xfer u_local (
    .cur_st    (cpu_cur),
    .active    (cpu_valid_i),
    .is_write  (cpu_write_i),
    .tag_match (cpu_match_i),
    .nxt_st    (cpu_nxt),
    .hit       (loc_hit),
    .req_vld   (loc_req),
    .req_op    (loc_op),
    .evict     (loc_evict)
  );

  logic       req_vld_d, evict_d, sup_d;
  logic [2:0] req_op_d;
  logic       hit_d;
  logic [1:0] cst_d, sst_d;

  always_comb begin
    req_vld_d = loc_req;
    req_op_d  = cpu_valid_i ? loc_op : bus_req_op_o;
    evict_d   = loc_evict;
    hit_d     = cpu_valid_i ? loc_hit : cpu_hit_o;
    cst_d     = cpu_valid_i ? cpu_nxt : cpu_state_o;
    sup_d     = snp_sup;
    sst_d     = snp_valid_i ? snp_nxt : snp_state_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req_vld_o <= 1'b0;
      bus_req_op_o  <= 3'd0;
      evict_o       <= 1'b0;
      cpu_hit_o     <= 1'b0;
      cpu_state_o   <= 2'd0;
      snp_supply_o  <= 1'b0;
      snp_state_o   <= 2'd0;
    end else begin
      bus_req_vld_o <= req_vld_d;
      bus_req_op_o  <= req_op_d;
      evict_o       <= evict_d;
      cpu_hit_o     <= hit_d;
      cpu_state_o   <= cst_d;
      snp_supply_o  <= sup_d;
      snp_state_o   <= sst_d;
    end
  end
endmodule

// File: rtl/wo_coherence_chk.sv
module wo_coherence_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_valid_i,
  input logic       snp_valid_i,
  input logic       snp_match_i,
  input logic [2:0] snp_op_i,
  input logic       bus_req_vld_o,
  input logic [2:0] bus_req_op_o,
  input logic       evict_o,
  input logic       cpu_hit_o,
  input logic [1:0] cpu_state_o,
  input logic       snp_supply_o,
  input logic [1:0] snp_state_o
);
  assert_supply_needs_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply_o |-> $past(snp_valid_i && snp_match_i));

  assert_no_supply_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snp_valid_i && (snp_op_i == 3'd2)) |-> !snp_supply_o);

  assert_rfo_snoop_invalidates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_supply_o && (($past(snp_op_i) == 3'd1) || ($past(snp_op_i) == 3'd4)))
      |-> (snp_state_o == 2'd0));

  assert_rfo_ends_modified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_vld_o && (bus_req_op_o == 3'd1)) |-> (cpu_state_o == 2'd3));

  assert_write_through_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_vld_o && (bus_req_op_o == 3'd2)) |-> (cpu_state_o == 2'd2));

  assert_evict_with_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evict_o |-> (bus_req_vld_o && !cpu_hit_o));

  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cpu_valid_i) |-> (!bus_req_vld_o && !evict_o));
endmodule

bind wo_coherence_ctrl wo_coherence_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_valid_i   (cpu_valid_i),
  .snp_valid_i   (snp_valid_i),
  .snp_match_i   (snp_match_i),
  .snp_op_i      (snp_op_i),
  .bus_req_vld_o (bus_req_vld_o),
  .bus_req_op_o  (bus_req_op_o),
  .evict_o       (evict_o),
  .cpu_hit_o     (cpu_hit_o),
  .cpu_state_o   (cpu_state_o),
  .snp_supply_o  (snp_supply_o),
  .snp_state_o   (snp_state_o)
);

// File: tb/wo_coherence_ctrl_test.sv
`timescale 1ns/1ps
module wo_coherence_ctrl_test;
  localparam int IDX_W = 4;
  localparam int LINES = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_valid, cpu_write, cpu_match, snp_valid, snp_match;
  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [2:0] snp_op;
  logic bus_req_vld, evict, cpu_hit, snp_supply;
  logic [2:0] bus_req_op;
  logic [1:0] cpu_state, snp_state;

  int n_tests = 0;
  int n_fail  = 0;
  int mdl [LINES];

  always #2 clk = ~clk;

  wo_coherence_ctrl #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_write_i(cpu_write), .cpu_idx_i(cpu_idx), .cpu_match_i(cpu_match),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_idx_i(snp_idx), .snp_match_i(snp_match),
    .bus_req_vld_o(bus_req_vld), .bus_req_op_o(bus_req_op), .evict_o(evict),
    .cpu_hit_o(cpu_hit), .cpu_state_o(cpu_state),
    .snp_supply_o(snp_supply), .snp_state_o(snp_state)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit cv, input bit cw, input int ci, input bit cm,
                      input bit sv, input int so, input int si, input bit sm,
                      input string ovr);
    int sst, snew, cst, cnew, eop;
    bit sact, esup, ehit, ereq, eev;
    string stag, ctag;
    // expected snoop effect
    sst  = mdl[si];
    sact = sv && sm && (sst != 0);
    esup = sact && (so == 0 || so == 1 || so == 3 || so == 4);
    snew = !esup ? sst : ((so == 0 || so == 3) ? 1 : 0);
    if (!sact)                     stag = "R9";
    else if (so == 0 || so == 3)   stag = "R7";
    else if (so == 1 || so == 4)   stag = "R8";
    else                           stag = "R9";
    if (sv) mdl[si] = snew;
    // expected local effect on post-snoop state
    cst  = mdl[ci];
    ehit = cm && (cst != 0);
    eev  = cv && !cm && (cst == 3);
    ereq = 1'b0; eop = 0; cnew = cst;
    if (!ehit) begin
      ereq = 1'b1; eop = cw ? 1 : 0; cnew = cw ? 3 : 1;
      ctag = cw ? "R5" : "R2";
    end else if (cw) begin
      if (cst == 1) begin ereq = 1'b1; eop = 2; cnew = 2; ctag = "R3"; end
      else begin cnew = 3; ctag = "R4"; end
    end else ctag = "R2";
    if (cv && sv && sm && si == ci) ctag = "R11";
    if (ovr != "") ctag = ovr;
    if (cv) mdl[ci] = cnew;

    @(negedge clk);
    cpu_valid = cv; cpu_write = cw; cpu_idx = IDX_W'(ci); cpu_match = cm;
    snp_valid = sv; snp_op = 3'(so); snp_idx = IDX_W'(si); snp_match = sm;
    #1;
    // R10: nothing appears in the request cycle
    chk(!bus_req_vld && !snp_supply && !evict, "R10", "pulse in request cycle",
        int'(bus_req_vld) + int'(snp_supply) + int'(evict), 0);
    @(negedge clk);
    cpu_valid = 1'b0; snp_valid = 1'b0;
    if (cv) begin
      chk(bus_req_vld == ereq, ctag, "bus_req_vld", int'(bus_req_vld), int'(ereq));
      if (ereq) chk(int'(bus_req_op) == eop, ctag, "bus_req_op", int'(bus_req_op), eop);
      chk(cpu_hit == ehit, ctag, "cpu_hit", int'(cpu_hit), int'(ehit));
      chk(int'(cpu_state) == cnew, ctag, "cpu_state", int'(cpu_state), cnew);
      chk(evict == eev, eev ? "R6" : ctag, "evict", int'(evict), int'(eev));
    end else begin
      chk(!bus_req_vld && !evict, "R10", "idle local pulses", int'(bus_req_vld) + int'(evict), 0);
    end
    if (sv) begin
      chk(snp_supply == esup, stag, "snp_supply", int'(snp_supply), int'(esup));
      chk(int'(snp_state) == snew, stag, "snp_state", int'(snp_state), snew);
    end else begin
      chk(!snp_supply, "R10", "idle snoop pulse", int'(snp_supply), 0);
    end
  endtask

  task automatic set_state(input int idx, input int s);
    step(1'b0, 1'b0, idx, 1'b0, 1'b1, 4, idx, 1'b1, "");
    case (s)
      1: step(1'b1, 1'b0, idx, 1'b1, 1'b0, 0, 0, 1'b0, "");
      2: begin
        step(1'b1, 1'b0, idx, 1'b1, 1'b0, 0, 0, 1'b0, "");
        step(1'b1, 1'b1, idx, 1'b1, 1'b0, 0, 0, 1'b0, "");
      end
      3: step(1'b1, 1'b1, idx, 1'b1, 1'b0, 0, 0, 1'b0, "");
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) mdl[i] = 0;
    rst_n = 1'b0;
    cpu_valid = 1'b0; cpu_write = 1'b0; cpu_idx = '0; cpu_match = 1'b0;
    snp_valid = 1'b0; snp_op = 3'd0; snp_idx = '0; snp_match = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk(!bus_req_vld && !evict && !snp_supply, "R1", "pulses after reset",
        int'(bus_req_vld) + int'(evict) + int'(snp_supply), 0);
    chk(cpu_state == 2'd0 && snp_state == 2'd0, "R1", "states after reset",
        int'(cpu_state) + int'(snp_state), 0);
    // R1: every line misses on first read
    for (int i = 0; i < LINES; i++) step(1'b1, 1'b0, i, 1'b1, 1'b0, 0, 0, 1'b0, "R1");

    // Snoop sweep: every start state x every op code x tag match
    for (int s = 0; s < 4; s++)
      for (int op = 0; op < 8; op++)
        for (int m = 0; m < 2; m++) begin
          set_state(5, s);
          step(1'b0, 1'b0, 0, 1'b0, 1'b1, op, 5, m[0], "");
        end

    // Local sweep: every start state x read/write x tag match (R2..R6)
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++)
        for (int m = 0; m < 2; m++) begin
          set_state(9, s);
          step(1'b1, w[0], 9, m[0], 1'b0, 0, 0, 1'b0, "");
        end

    // R11: snoop and local access on the same index in one cycle
    for (int s = 0; s < 4; s++)
      for (int op = 0; op < 5; op++)
        for (int w = 0; w < 2; w++) begin
          set_state(3, s);
          step(1'b1, w[0], 3, 1'b1, 1'b1, op, 3, 1'b1, "");
        end

    // Independent indices in one cycle
    set_state(7, 3);
    set_state(8, 2);
    step(1'b1, 1'b1, 8, 1'b1, 1'b1, 1, 7, 1'b1, "");
    step(1'b1, 1'b0, 7, 1'b1, 1'b1, 0, 8, 1'b1, "");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule